// File: doc/BRIEF.md
# Run-Time Partitionable Lane Multiplier

This block multiplies two 64-bit unsigned operands. Each operation also picks how the operands are split into independent lanes: one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Each lane produces its own double-width product, and the products are packed side by side into a 128-bit result. A new operation may enter on every clock. Each operation carries its own lane mode, so consecutive operations may use different partitions.

Internally the block forms every byte-by-byte 8x8 product of the two operands. It zeroes the products whose two bytes fall in different lanes under the selected mode. The remaining products, each shifted to its byte weight, are summed by carry-save compression spread over two register stages and then by a single carry-propagate adder in a third stage. A control module carries the valid bit and the mode alongside the data. It hands the datapath a small bundle of strobes: the product enable mask, the per-stage load enables and the output-stage mode.

Top module: `simd_mul_top`

## Requirements
- R1: With mode 2'b00 (one lane), `resProd` is the full 128-bit unsigned product `inA * inB`.
- R2: With mode 2'b01 (two lanes of 32 bits), lane k (k = 0..1) takes operand bits [32k+31:32k], and its 64-bit product appears on `resProd[64k+63:64k]`.
- R3: With mode 2'b10 (four lanes of 16 bits), lane k takes operand bits [16k+15:16k], and its 32-bit product appears on `resProd[32k+31:32k]`.
- R4: With mode 2'b11 (eight lanes of 8 bits), lane k takes operand bits [8k+7:8k], and its 16-bit product appears on `resProd[16k+15:16k]`.
- R5: No lane's result is affected by operand bits of another lane, and no carry passes from one lane's result field into the next, including when every operand bit is one.
- R6: `resValid` is high exactly three clock cycles after a cycle in which `inValid` was high, and `resProd` then holds that operation's result. One operation is accepted per cycle.
- R7: The mode is captured with each operation. Back-to-back operations with different modes each produce the result of their own mode.
- R8: While `rstN` is low, and in the first cycles after it is released, `resValid` is low.
- R9: A cycle with `inValid` low produces no valid result three cycles later, whatever values the operand and mode inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | An operation is presented this cycle |
| inMode | input | 2 | Lane mode: 00 one lane, 01 two, 10 four, 11 eight |
| inA | input | 64 | Multiplicand |
| inB | input | 64 | Multiplier |
| resValid | output | 1 | `resProd` holds a result this cycle |
| resProd | output | 128 | Packed lane products |

## Verification
The hardest condition to reach from the ports is a lane whose product carries into its top bit while its neighbour's operands would, if leaked, change that top bit. Random operands seldom produce this, and it must also happen while the mode changes from one cycle to the next. The stimulus therefore drives all-ones and high-bit-only operands in every mode, back to back, in a rotating mode order. Random traffic with idle bubbles and random garbage on the operand inputs follows. A behavioural reference queue compares every clock.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = 8;
  localparam int OP_W       = BYTE_W * NUM_BYTES;
  localparam int PROD_W     = 2 * OP_W;
  localparam int NUM_PP     = NUM_BYTES * NUM_BYTES;
  localparam int NUM_STAGES = 3;
  localparam int MODE_W     = 2;
  localparam int MAX_SHIFT  = $clog2(NUM_BYTES);

  typedef enum logic [MODE_W-1:0] {
    MODE_X1 = 2'b00,
    MODE_X2 = 2'b01,
    MODE_X4 = 2'b10,
    MODE_X8 = 2'b11
  } laneMode_e;

  typedef struct packed {
    logic [NUM_PP-1:0]     ppEnable;
    logic [NUM_STAGES-1:0] stageLoad;
    logic                  outValid;
    laneMode_e             outMode;
  } dpStrobe_t;
endpackage

// File: rtl/simd_mul_csa.sv
module simd_mul_csa #(
  parameter int N = 8,
  parameter int W = 128
) (
  input  logic [W-1:0] vecIn [N],
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);
  logic [W-1:0] work [N];
  logic [W-1:0] nxt  [N];

  always_comb begin
    automatic int cnt = N;
    automatic int grp = 0;
    automatic int rem = 0;
    work = vecIn;
    nxt  = vecIn;
    for (int lvl = 0; lvl < N; lvl++) begin
      grp = cnt / 3;
      rem = cnt - 3 * grp;
      for (int t = 0; t < N; t++) nxt[t] = '0;
      if (cnt > 2) begin
        for (int t = 0; t < N / 3; t++) begin
          if (t < grp) begin
            nxt[2*t]   = work[3*t] ^ work[3*t+1] ^ work[3*t+2];
            nxt[2*t+1] = ((work[3*t] & work[3*t+1]) |
                          (work[3*t] & work[3*t+2]) |
                          (work[3*t+1] & work[3*t+2])) << 1;
          end
        end
        for (int t = 0; t < 2; t++) begin
          if (t < rem) nxt[2*grp+t] = work[3*grp+t];
        end
        work = nxt;
        cnt  = 2 * grp + rem;
      end
    end
    sumOut   = work[0];
    carryOut = work[1];
  end
endmodule

// File: rtl/simd_mul_ctrl.sv
module simd_mul_ctrl
  import simd_mul_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [MODE_W-1:0]     inMode,
  output dpStrobe_t             strobe,
  output logic                  resValid
);
  logic [NUM_STAGES-1:0] validPipe;
  laneMode_e             modePipe [NUM_STAGES];
  logic [NUM_PP-1:0]     pairMask;

  always_comb begin
    automatic int sh = MAX_SHIFT - int'(inMode);
    for (int i = 0; i < NUM_BYTES; i++) begin
      for (int j = 0; j < NUM_BYTES; j++) begin
        pairMask[i*NUM_BYTES+j] = ((i >> sh) == (j >> sh));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validPipe <= '0;
      for (int k = 0; k < NUM_STAGES; k++) modePipe[k] <= MODE_X1;
    end else begin
      validPipe[0] <= inValid;
      modePipe[0]  <= laneMode_e'(inMode);
      for (int k = 1; k < NUM_STAGES; k++) begin
        validPipe[k] <= validPipe[k-1];
        modePipe[k]  <= modePipe[k-1];
      end
    end
  end

  always_comb begin
    strobe.ppEnable  = pairMask;
    strobe.stageLoad = {validPipe[NUM_STAGES-2:0], inValid};
    strobe.outValid  = validPipe[NUM_STAGES-1];
    strobe.outMode   = modePipe[NUM_STAGES-1];
  end

  assign resValid = validPipe[NUM_STAGES-1];

  // Cross-lane products are excluded: lane-local pair count halves per mode step
  assert_pair_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pairMask) == (NUM_PP >> inMode));

  generate
    for (genvar k = 1; k < NUM_STAGES; k++) begin : g_chain
      assert_valid_chain_R6: assert property (@(posedge clk) disable iff (!rstN)
        validPipe[k] == $past(validPipe[k-1]));
    end
  endgenerate

  assert_first_stage_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !validPipe[0]);
endmodule

// File: rtl/simd_mul_dp.sv
module simd_mul_dp
  import simd_mul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [OP_W-1:0]   inA,
  input  logic [OP_W-1:0]   inB,
  output logic [PROD_W-1:0] resProd
);
  localparam int GRP_OUT = 2 * NUM_BYTES;

  logic [PROD_W-1:0] ppVec    [NUM_BYTES][NUM_BYTES];
  logic [PROD_W-1:0] grpSum   [NUM_BYTES];
  logic [PROD_W-1:0] grpCarry [NUM_BYTES];
  logic [PROD_W-1:0] s1Vec    [GRP_OUT];
  logic [PROD_W-1:0] s2SumNext, s2CarryNext;
  logic [PROD_W-1:0] s2Sum, s2Carry;

  always_comb begin
    for (int i = 0; i < NUM_BYTES; i++) begin
      for (int j = 0; j < NUM_BYTES; j++) begin
        automatic logic [2*BYTE_W-1:0] pp = inA[BYTE_W*i +: BYTE_W] * inB[BYTE_W*j +: BYTE_W];
        ppVec[i][j] = strobe.ppEnable[i*NUM_BYTES+j]
                    ? (PROD_W'(pp) << (BYTE_W * (i + j))) : '0;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_row
      simd_mul_csa #(.N(NUM_BYTES), .W(PROD_W)) uRow (
        .vecIn   (ppVec[g]),
        .sumOut  (grpSum[g]),
        .carryOut(grpCarry[g])
      );
    end
  endgenerate

  simd_mul_csa #(.N(GRP_OUT), .W(PROD_W)) uMerge (
    .vecIn   (s1Vec),
    .sumOut  (s2SumNext),
    .carryOut(s2CarryNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < GRP_OUT; g++) s1Vec[g] <= '0;
      s2Sum   <= '0;
      s2Carry <= '0;
      resProd <= '0;
    end else begin
      if (strobe.stageLoad[0]) begin
        for (int g = 0; g < NUM_BYTES; g++) begin
          s1Vec[2*g]   <= grpSum[g];
          s1Vec[2*g+1] <= grpCarry[g];
        end
      end
      if (strobe.stageLoad[1]) begin
        s2Sum   <= s2SumNext;
        s2Carry <= s2CarryNext;
      end
      if (strobe.stageLoad[2]) resProd <= s2Sum + s2Carry;
    end
  end

  // A W x W product never has an all-ones upper half
  function automatic logic laneBoundOk(logic [PROD_W-1:0] p, laneMode_e m);
    automatic int w = OP_W >> int'(m);
    automatic int lanes = 1 << int'(m);
    automatic logic [PROD_W-1:0] mask = {PROD_W{1'b1}} >> (PROD_W - w);
    laneBoundOk = 1'b1;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (k < lanes && (((p >> (2 * w * k + w)) & mask) == mask)) laneBoundOk = 1'b0;
    end
  endfunction

  assert_lane_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.outValid |-> laneBoundOk(resProd, strobe.outMode));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stageLoad[1] |=> ($stable(s2Sum) && $stable(s2Carry)));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stageLoad[2] |=> $stable(resProd));
endmodule

// File: rtl/simd_mul_top.sv
module simd_mul_top
  import simd_mul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inMode,
  input  logic [63:0]       inA,
  input  logic [63:0]       inB,
  output logic              resValid,
  output logic [127:0]      resProd
);
  dpStrobe_t strobe;

  simd_mul_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inMode  (inMode),
    .strobe  (strobe),
    .resValid(resValid)
  );

  simd_mul_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inA    (inA),
    .inB    (inB),
    .resProd(resProd)
  );
endmodule

// File: tb/sim_simd_mul_top.sv
module sim_simd_mul_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   inMode = 2'b00;
  logic [63:0]  inA = '0;
  logic [63:0]  inB = '0;
  logic         resValid;
  logic [127:0] resProd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic         mV [3];
  logic [127:0] mP [3];
  logic [1:0]   mM [3];
  logic [1:0]   lastMode = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_mul_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .inA(inA), .inB(inB), .resValid(resValid), .resProd(resProd)
  );

  function automatic logic [127:0] refMul(logic [63:0] a, logic [63:0] b, logic [1:0] m);
    automatic int w = 64 >> m;
    automatic int lanes = 1 << m;
    automatic logic [127:0] mask = (128'd1 << w) - 128'd1;
    automatic logic [127:0] r = '0;
    for (int k = 0; k < lanes; k++) begin
      automatic logic [127:0] aL = ({64'd0, a} >> (k * w)) & mask;
      automatic logic [127:0] bL = ({64'd0, b} >> (k * w)) & mask;
      r = r | ((aL * bL) << (2 * w * k));
    end
    return r;
  endfunction

  function automatic string modeTag(logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 3; k++) begin
        mV[k] <= 1'b0; mP[k] <= '0; mM[k] <= 2'b00;
      end
    end else begin
      mV[0] <= inValid;
      mP[0] <= refMul(inA, inB, inMode);
      mM[0] <= inMode;
      for (int k = 1; k < 3; k++) begin
        mV[k] <= mV[k-1]; mP[k] <= mP[k-1]; mM[k] <= mM[k-1];
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        checks++;
        if (resValid !== 1'b0) begin
          errors++;
          $display("FAIL R8 resValid during reset: actual=%b expected=0", resValid);
        end
      end else begin
        checks++;
        if (resValid !== mV[2]) begin
          errors++;
          $display("FAIL R6/R9 resValid: actual=%b expected=%b", resValid, mV[2]);
        end else if (mV[2]) begin
          checks++;
          if (resProd !== mP[2]) begin
            errors++;
            $display("FAIL %s%s product mode=%b: actual=%h expected=%h",
                     modeTag(mM[2]), (mM[2] != lastMode) ? " R7 R5" : " R5",
                     mM[2], resProd, mP[2]);
          end
          lastMode = mM[2];
        end
      end
    end
  end

  task automatic issue(logic v, logic [1:0] m, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    inValid = v; inMode = m; inA = a; inB = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R8: no valid result right after reset release
    repeat (3) issue(1'b0, 2'b00, '0, '0);

    // R5: all-ones and top-bit operands in every mode, back to back (R7)
    for (int m = 0; m < 4; m++) issue(1'b1, 2'(m), {64{1'b1}}, {64{1'b1}});
    for (int m = 3; m >= 0; m--) issue(1'b1, 2'(m), {8{8'h80}}, {8{8'hFF}});
    for (int m = 0; m < 4; m++) issue(1'b1, 2'(m), 64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_FFFF_0001);
    // R1: simple known values
    issue(1'b1, 2'b00, 64'd3, 64'd5);
    issue(1'b1, 2'b00, 64'h1_0000_0000, 64'h1_0000_0000);
    // R9: idle cycles with garbage on inputs
    for (int i = 0; i < 4; i++) issue(1'b0, 2'(i), {$urandom, $urandom}, {$urandom, $urandom});

    // R2 R3 R4 R6 R7: random traffic with bubbles
    for (int i = 0; i < 600; i++) begin
      automatic logic v = ($urandom % 4) != 0;
      issue(v, 2'($urandom % 4), {$urandom, $urandom}, {$urandom, $urandom});
    end
    repeat (6) issue(1'b0, 2'b00, '0, '0);

    // R8: reset mid-stream clears pending results
    issue(1'b1, 2'b11, {$urandom, $urandom}, {$urandom, $urandom});
    @(negedge clk); rstN = 1'b0; inValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule